// File: doc/BRIEF.md
# Multiplexed Bus Cycle Demultiplexer

This block watches the time-shared address and status pins of a 16-bit processor bus and rebuilds each bus cycle as one record. While the address strobe is high it captures the twenty address bits, the three cycle-type status bits and the byte-lane pins. Once the strobe drops, it takes the origin bit from the top shared pin, which now shows whether the CPU or a DMA/refresh agent started the cycle. It then waits for the passive status code that closes the cycle.

When the cycle closes, the block raises a one-clock valid pulse. The pulse comes with the latched address, the cycle kind, the byte-lane code, the origin bit and a protocol error flag. The error flag marks a read strobe seen during a write-type cycle. All bus inputs are taken to be synchronous to the block clock and are sampled on its rising edge.

Top module: `mbd_top`

## Requirements
- R1: The record address is the 20-bit value {ad_hi, ad_lo} sampled on the last clock with ale high. Values on the shared pins while ale is low (the data phase drives ad_hi[2:0] to 0) do not change it.
- R2: The record kind equals the stat code sampled with ale high: 0 interrupt acknowledge, 1 I/O read, 2 I/O write, 3 halt, 4 instruction fetch, 5 memory read, 6 memory write.
- R3: The record lane code is {a0, bhe_n} sampled with ale high: 0 word, 1 even byte, 2 odd byte, 3 refresh.
- R4: The record origin bit (txn_dma) is ad_hi[3] sampled on the first clock after ale falls: 0 means CPU, 1 means DMA or refresh.
- R5: When stat is 7 (passive) with ale low during an open cycle, txn_valid is high for exactly one clock, starting at the edge that samples that code.
- R6: An ale pulse that carries stat 7 opens no cycle, and passive status while idle gives no pulse.
- R7: txn_err is 1 in the record only when rd_n was sampled low in the data phase of a cycle of kind 2 or 6. Otherwise it is 0.
- R8: After reset, txn_valid is 0 and every record field is 0.
- R9: A data phase of any number of clocks yields exactly one pulse, and only after the passive code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe, high during the address phase |
| ad_hi | input | 4 | Shared upper address/status pins (bit 3 is address 19 or origin) |
| ad_lo | input | 16 | Multiplexed low address/data pins |
| stat | input | 3 | Cycle-type status code |
| bhe_n | input | 1 | Active-low upper byte enable |
| a0 | input | 1 | Address bit 0 |
| rd_n | input | 1 | Active-low read strobe |
| txn_valid | output | 1 | One-clock pulse marking a completed record |
| txn_addr | output | 20 | Latched address of the record |
| txn_kind | output | 3 | Cycle kind code |
| txn_lane | output | 2 | Byte-lane code |
| txn_dma | output | 1 | Origin bit, 1 for DMA or refresh |
| txn_err | output | 1 | Read strobe seen in a write cycle |

## Verification
The record fields and the pulse leave registers that are written at the edge which samples the passive code. They are therefore due one clock after the passive code is driven, and they are read at the next falling edge. The pulse is checked low again one clock later. The origin and error state are taken at the edge after the strobe falls, which is always ahead of the closing edge, so every record field is checked at that single point. Inputs change only on falling edges, so no sample depends on the order of processes at a rising edge.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  typedef enum logic [2:0] {
    K_INTA  = 3'd0,
    K_IORD  = 3'd1,
    K_IOWR  = 3'd2,
    K_HALT  = 3'd3,
    K_FETCH = 3'd4,
    K_MEMRD = 3'd5,
    K_MEMWR = 3'd6,
    K_IDLE  = 3'd7
  } cyc_kind_e;

  typedef enum logic [1:0] {
    L_WORD = 2'd0,
    L_EVEN = 2'd1,
    L_ODD  = 2'd2,
    L_RFSH = 2'd3
  } lane_e;

  // A cycle in which the processor, not the device, drives the data bus.
  function automatic logic kind_writes(cyc_kind_e k);
    return (k == K_IOWR) || (k == K_MEMWR);
  endfunction

  // Lane code is the pair {a0, bhe_n}.
  function automatic lane_e lane_of(logic a0, logic bhe_n);
    return lane_e'({a0, bhe_n});
  endfunction
endpackage

// File: rtl/mbd_phase_latch.sv
module mbd_phase_latch
  import mbd_pkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 16,
  localparam int AW = HI_W + LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [HI_W-1:0] ad_hi,
  input  logic [LO_W-1:0] ad_lo,
  input  logic [2:0]      stat,
  input  logic            bhe_n,
  input  logic            a0,
  output logic [AW-1:0]   lat_addr,
  output cyc_kind_e       lat_kind,
  output lane_e           lat_lane,
  output logic            ale_fall
);
  logic ale_q;

  // Transparent while the strobe is high, frozen once it drops.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      lat_addr <= '0;
      lat_kind <= K_INTA;
      lat_lane <= L_WORD;
    end else begin
      ale_q <= ale;
      if (ale) begin
        lat_addr <= {ad_hi, ad_lo};
        lat_kind <= cyc_kind_e'(stat);
        lat_lane <= lane_of(a0, bhe_n);
      end
    end
  end

  assign ale_fall = ale_q & ~ale;

  // R1: on the first low-strobe clock, the latch holds the last high-strobe pins
  p_addr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |-> lat_addr == $past({ad_hi, ad_lo}));

  // R1: data-phase pin values never reach the latch
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && ale_q == 1'b0 && $past(!ale)) |-> $stable(lat_addr));
endmodule

// File: rtl/mbd_txn_track.sv
module mbd_txn_track
  import mbd_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [2:0]    stat,
  input  logic          rd_n,
  input  logic          s6,
  input  logic          ale_fall,
  input  logic [AW-1:0] lat_addr,
  input  cyc_kind_e     lat_kind,
  input  lane_e         lat_lane,
  output logic          txn_valid,
  output logic [AW-1:0] txn_addr,
  output cyc_kind_e     txn_kind,
  output lane_e         txn_lane,
  output logic          txn_dma,
  output logic          txn_err
);
  logic active, origin_q, err_q;
  logic start_evt, end_evt, rd_clash, take_s6;

  assign start_evt = ale && (cyc_kind_e'(stat) != K_IDLE);
  assign end_evt   = active && !ale && (cyc_kind_e'(stat) == K_IDLE);
  assign take_s6   = active && ale_fall;
  assign rd_clash  = active && !ale && !rd_n && kind_writes(lat_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      origin_q  <= 1'b0;
      err_q     <= 1'b0;
      txn_valid <= 1'b0;
      txn_addr  <= '0;
      txn_kind  <= K_INTA;
      txn_lane  <= L_WORD;
      txn_dma   <= 1'b0;
      txn_err   <= 1'b0;
    end else begin
      txn_valid <= end_evt;
      if (start_evt) begin
        active   <= 1'b1;
        origin_q <= 1'b0;
        err_q    <= 1'b0;
      end else begin
        if (end_evt)  active   <= 1'b0;
        if (take_s6)  origin_q <= s6;
        if (rd_clash) err_q    <= 1'b1;
      end
      if (end_evt) begin
        txn_addr <= lat_addr;
        txn_kind <= lat_kind;
        txn_lane <= lat_lane;
        txn_dma  <= origin_q;
        txn_err  <= err_q | rd_clash;
      end
    end
  end

  // R5: the pulse lasts one clock
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> !txn_valid);

  // R5: the pulse follows a passive code sampled with the strobe low
  p_pulse_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ($past(stat) == 3'd7) && !$past(ale));

  // R6: a strobe carrying the passive code opens nothing
  p_no_open_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && ale && stat == 3'd7) |=> !active);

  // R7: an error record is always a write kind
  p_err_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_err) |-> kind_writes(txn_kind));
endmodule

// File: rtl/mbd_top.sv
module mbd_top
  import mbd_pkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 16,
  localparam int AW = HI_W + LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [HI_W-1:0] ad_hi,
  input  logic [LO_W-1:0] ad_lo,
  input  logic [2:0]      stat,
  input  logic            bhe_n,
  input  logic            a0,
  input  logic            rd_n,
  output logic            txn_valid,
  output logic [AW-1:0]   txn_addr,
  output logic [2:0]      txn_kind,
  output logic [1:0]      txn_lane,
  output logic            txn_dma,
  output logic            txn_err
);
  logic [AW-1:0] lat_addr;
  cyc_kind_e     lat_kind, rec_kind;
  lane_e         lat_lane, rec_lane;
  logic          ale_fall;

  mbd_phase_latch #(.HI_W(HI_W), .LO_W(LO_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_hi(ad_hi), .ad_lo(ad_lo),
    .stat(stat), .bhe_n(bhe_n), .a0(a0),
    .lat_addr(lat_addr), .lat_kind(lat_kind), .lat_lane(lat_lane),
    .ale_fall(ale_fall)
  );

  mbd_txn_track #(.AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n), .ale(ale), .stat(stat), .rd_n(rd_n),
    .s6(ad_hi[HI_W-1]), .ale_fall(ale_fall),
    .lat_addr(lat_addr), .lat_kind(lat_kind), .lat_lane(lat_lane),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_kind(rec_kind),
    .txn_lane(rec_lane), .txn_dma(txn_dma), .txn_err(txn_err)
  );

  assign txn_kind = rec_kind;
  assign txn_lane = rec_lane;
endmodule

// File: tb/sim_mbd_top.sv
module sim_mbd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [3:0]  ad_hi = '0;
  logic [15:0] ad_lo = '0;
  logic [2:0]  stat = 3'd7;
  logic        bhe_n = 1'b1;
  logic        a0 = 1'b0;
  logic        rd_n = 1'b1;
  logic        txn_valid;
  logic [19:0] txn_addr;
  logic [2:0]  txn_kind;
  logic [1:0]  txn_lane;
  logic        txn_dma, txn_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbd_top u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_hi(ad_hi), .ad_lo(ad_lo),
    .stat(stat), .bhe_n(bhe_n), .a0(a0), .rd_n(rd_n),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_kind(txn_kind),
    .txn_lane(txn_lane), .txn_dma(txn_dma), .txn_err(txn_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full bus cycle: address phase, data phase of 1+waits clocks, passive.
  task automatic run_cycle(input logic [19:0] addr, input logic [2:0] kind,
                           input logic la0, input logic lbhe_n, input logic s6,
                           input logic lrd_n, input int waits);
    logic exp_err;
    exp_err = !lrd_n && (kind == 3'd2 || kind == 3'd6);
    @(negedge clk);
    ale = 1'b1; ad_hi = addr[19:16]; ad_lo = addr[15:0];
    stat = kind; a0 = la0; bhe_n = lbhe_n; rd_n = 1'b1;
    @(negedge clk);
    ale = 1'b0; ad_hi = {s6, 3'b000}; ad_lo = ~addr[15:0]; rd_n = lrd_n;
    a0 = ~la0; bhe_n = ~lbhe_n;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      check("R9 no pulse mid data phase", {31'd0, txn_valid}, 32'd0);
    end
    @(negedge clk);
    check("R9 no pulse before passive", {31'd0, txn_valid}, 32'd0);
    stat = 3'd7; rd_n = 1'b1;
    @(negedge clk);
    check("R5 pulse after passive", {31'd0, txn_valid}, 32'd1);
    check("R1 address", {12'd0, txn_addr}, {12'd0, addr});
    check("R2 kind", {29'd0, txn_kind}, {29'd0, kind});
    check("R3 lane", {30'd0, txn_lane}, {30'd0, la0, lbhe_n});
    check("R4 origin", {31'd0, txn_dma}, {31'd0, s6});
    check("R7 rd error flag", {31'd0, txn_err}, {31'd0, exp_err});
    ad_hi = '0;
    @(negedge clk);
    check("R5 pulse one clock", {31'd0, txn_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R8 valid after reset", {31'd0, txn_valid}, 32'd0);
    check("R8 record after reset",
          {5'd0, txn_addr, txn_kind, txn_lane, txn_dma, txn_err}, 32'd0);
  endtask

  task automatic t_kinds();
    for (int k = 0; k < 7; k++)
      run_cycle(20'h1_0000 + 20'(k * 20'h1357), 3'(k), 1'b0, 1'b0, 1'b0, 1'b1, 0);
  endtask

  task automatic t_lanes();
    for (int l = 0; l < 4; l++)
      run_cycle(20'h2_4680 + 20'(l), 3'd5, l[1], l[0], 1'b0, 1'b0, 0);
  endtask

  task automatic t_origin_and_addr();
    run_cycle(20'hF_1234, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 0); // R4 dma, R1 high bits kept
    run_cycle(20'hE_FFFF, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1); // R4 cpu
  endtask

  task automatic t_errors();
    run_cycle(20'h3_0010, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 0); // R7 mem write with rd
    run_cycle(20'h3_0020, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2); // R7 io write with rd
    run_cycle(20'h3_0030, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0); // R7 io read, no flag
    run_cycle(20'h3_0040, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 0); // R7 write, rd high
  endtask

  task automatic t_passive_strobe();
    @(negedge clk);
    ale = 1'b1; stat = 3'd7; ad_hi = 4'hA; ad_lo = 16'h5555;
    @(negedge clk);
    ale = 1'b0; ad_hi = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R6 no pulse for passive strobe", {31'd0, txn_valid}, 32'd0);
    end
  endtask

  task automatic t_long_wait();
    run_cycle(20'h5_A5A5, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 6); // R9 long data phase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_kinds();
    t_lanes();
    t_origin_and_addr();
    t_errors();
    t_passive_strobe();
    t_long_wait();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule